// File: doc/BRIEF.md
# NOR Flash Operation Sequencer

This block sits between a host and a bus-cycle engine that drives a parallel NOR flash. The host posts abstract operations into a small queue: read, program, chip erase, reset, suspend and resume. The sequencer takes entries from the queue one at a time and rejects any entry that is illegal in the current state. It expands each legal entry into the fixed list of flash write cycles the operation needs. Every cycle starts with two unlock writes, except the short reset, suspend and resume forms. After a program, an erase or a resume, the sequencer polls the flash with reads until the status toggle bit settles. When the flash reports a failure, it issues a reset write to clear it.

Both data interfaces use valid/ready. On the host side, `in_valid` with `in_ready` high transfers one entry, and `in_ready` drops while the queue is full. On the engine side, the block holds `bus_valid` and every bus field steady until `bus_ready` is sampled high. The engine returns read data later, marked by `bus_rvalid`, and the sequencer always accepts that data. `busy`, `done`, `error` and `rsp_data` are plain status pins.

Op codes on `in_op`: 0 read, 1 program, 2 chip erase, 3 reset, 4 suspend, 5 resume. Codes 6 and 7 are illegal.

Top module: `nor_op_sequencer`

## Requirements
- R1: The queue holds DEPTH entries and hands them on in arrival order; `in_ready` is low while DEPTH entries are held.
- R2: A program (op 1) produces exactly four writes: 555h/AAh, 2AAh/55h, 555h/A0h, then the entry's address with its data.
- R3: A chip erase (op 2) produces exactly six writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h.
- R4: A reset (op 3) with `in_data[0]`=0 produces one write, 555h/F0h. With `in_data[0]`=1 it produces three writes: 555h/AAh, 2AAh/55h, 555h/F0h. In both cases `done` pulses next.
- R5: A read (op 0) produces one bus read at the entry's address and no write; `rsp_data` then holds the returned word while `done` pulses.
- R6: After the writes of a program, an erase or a resume, the block reads the entry's address repeatedly. It pulses `done` once bit 6 has the same value on two consecutive reads.
- R7: If a poll read shows bit 6 changed from the previous read and bit 5 set, the block issues one 555h/F0h write and then pulses `error`, not `done`.
- R8: Op codes 6 and 7 are rejected with an `error` pulse and no bus cycle. So are a suspend while idle, a resume while not suspended, and a program or erase while suspended.
- R9: A suspend queued while a program or resume is polling produces a single 555h/B0h write and a `done` pulse, and the block enters the suspended state. In that state a read is served, and a resume produces a single 555h/30h write followed by polling.
- R10: A suspend queued while a chip erase is polling is discarded without a bus cycle or a response, and the erase runs to `done`.
- R11: While busy, the block takes only suspend entries from the queue; other entries wait until it is idle.
- R12: Once `bus_valid` is high, it stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until `bus_ready` is high.
- R13: After reset, `busy`, `done`, `error` and `bus_valid` are low and `in_ready` is high. `done` and `error` are one-cycle pulses, never high together, and `busy` falls in the cycle one of them pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host entry valid |
| in_ready | output | 1 | Queue can take an entry |
| in_op | input | 3 | Operation code |
| in_addr | input | AW | Target flash word address |
| in_data | input | DW | Program data; bit 0 selects long reset |
| bus_valid | output | 1 | Bus cycle request valid |
| bus_ready | input | 1 | Engine accepts the cycle |
| bus_we | output | 1 | 1 write cycle, 0 read cycle |
| bus_addr | output | AW | Cycle address |
| bus_wdata | output | DW | Write data |
| bus_rvalid | input | 1 | Read data returned |
| bus_rdata | input | DW | Returned read word |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection or flash-failure pulse |
| rsp_data | output | DW | Word from the last read operation |

## Verification
Each operation kind is tried alone against a flash model whose toggle bit flips for a chosen number of reads. The order and values of the logged write cycles separate program, erase, and the short and long resets. A toggle that never settles with bit 5 set separates the recovery path from normal completion. Suspends placed under a program and under an erase show the difference between honouring a suspend and dropping it. Filling the queue behind a long program, with a stalling engine, shows back-pressure, in-order service and the hold rule.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_ERASE  = 3'd2;
  localparam logic [2:0] OP_RESET  = 3'd3;
  localparam logic [2:0] OP_SUSP   = 3'd4;
  localparam logic [2:0] OP_RESUME = 3'd5;

  localparam logic [11:0] ADR_KEY_A = 12'h555;
  localparam logic [11:0] ADR_KEY_B = 12'h2AA;
  localparam logic [7:0]  KEY_A     = 8'hAA;
  localparam logic [7:0]  KEY_B     = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERS1  = 8'h80;
  localparam logic [7:0]  CMD_ERS2  = 8'h10;
  localparam logic [7:0]  CMD_RST   = 8'hF0;
  localparam logic [7:0]  CMD_SUSP  = 8'hB0;
  localparam logic [7:0]  CMD_RES   = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_POLL_CHK, ST_POLL_REQ, ST_POLL_WAIT, ST_READ_REQ, ST_READ_WAIT
  } seq_st_e;
endpackage

// File: rtl/nfc_fifo.sv
module nfc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] out_word
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push, take;

  assign in_ready  = (cnt_q != CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_word  = mem[rd_q];
  assign push      = in_valid && in_ready;
  assign take      = pop && out_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= in_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (take) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(take);
    end
  end

  // R1: an accepted entry with no removal grows the occupancy by one
  assert_fifo_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !take) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R1: the consumer removes only entries that exist
  assert_fifo_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> out_valid);
endmodule

// File: rtl/nfc_decode.sv
module nfc_decode
  import nfc_pkg::*;
(
  input  logic [2:0] op,
  input  logic       suspended,
  input  logic       polling,
  input  logic [2:0] run_op,
  output logic       legal,
  output logic       drop
);
  always_comb begin
    legal = 1'b0;
    drop  = 1'b0;
    if (polling) begin
      if (op == OP_SUSP) begin
        if (run_op == OP_ERASE) drop = 1'b1;
        else                    legal = 1'b1;
      end
    end else begin
      case (op)
        OP_READ, OP_RESET: legal = 1'b1;
        OP_PROG, OP_ERASE: legal = !suspended;
        OP_RESUME:         legal = suspended;
        default:           legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/nfc_expand.sv
module nfc_expand
  import nfc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic [2:0]    op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data,
  output logic          last
);
  localparam logic [AW-1:0] A_555 = AW'(ADR_KEY_A);
  localparam logic [AW-1:0] A_2AA = AW'(ADR_KEY_B);

  logic [7:0] cmd;

  always_comb begin
    case (op)
      OP_PROG:   cmd = CMD_PROG;
      OP_ERASE:  cmd = CMD_ERS1;
      OP_SUSP:   cmd = CMD_SUSP;
      OP_RESUME: cmd = CMD_RES;
      default:   cmd = CMD_RST;
    endcase
  end

  always_comb begin
    cyc_addr = A_555;
    cyc_data = DW'(KEY_A);
    case (step)
      3'd1: begin cyc_addr = A_2AA; cyc_data = DW'(KEY_B); end
      3'd2: cyc_data = DW'(cmd);
      3'd3: if (op == OP_PROG) begin
              cyc_addr = tgt_addr;
              cyc_data = tgt_data;
            end
      3'd4: begin cyc_addr = A_2AA; cyc_data = DW'(KEY_B); end
      3'd5: cyc_data = DW'(CMD_ERS2);
      default: ;
    endcase
    case (op)
      OP_PROG:  last = (step == 3'd3);
      OP_ERASE: last = (step == 3'd5);
      default:  last = (step == 3'd2);
    endcase
  end
endmodule

// File: rtl/nor_op_sequencer.sv
module nor_op_sequencer
  import nfc_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_rvalid,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [DW-1:0] rsp_data
);
  localparam int EW = 3 + AW + DW;

  seq_st_e       st_q;
  logic [2:0]    op_q, step_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rsp_q;
  logic          prev6_q, first_q, rec_q, susp_q, done_q, err_q;

  logic          head_valid, pop, legal, drop, last;
  logic [EW-1:0] head;
  logic [2:0]    h_op, start_step;
  logic [AW-1:0] h_addr, cyc_addr;
  logic [DW-1:0] h_data, cyc_data;

  nfc_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word({in_op, in_addr, in_data}), .pop(pop),
    .out_valid(head_valid), .out_word(head)
  );

  assign {h_op, h_addr, h_data} = head;

  nfc_decode u_dec (
    .op(h_op), .suspended(susp_q), .polling(st_q != ST_IDLE),
    .run_op(op_q), .legal(legal), .drop(drop)
  );

  nfc_expand #(.AW(AW), .DW(DW)) u_exp (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .cyc_addr(cyc_addr), .cyc_data(cyc_data), .last(last)
  );

  assign start_step = (h_op == OP_PROG || h_op == OP_ERASE ||
                       (h_op == OP_RESET && h_data[0])) ? 3'd0 : 3'd2;

  assign pop = head_valid && ((st_q == ST_IDLE) ||
                              (st_q == ST_POLL_CHK && h_op == OP_SUSP));

  assign bus_valid = (st_q == ST_WRITE) || (st_q == ST_POLL_REQ) || (st_q == ST_READ_REQ);
  assign bus_we    = (st_q == ST_WRITE);
  assign bus_addr  = (st_q == ST_WRITE) ? cyc_addr : addr_q;
  assign bus_wdata = (st_q == ST_WRITE) ? cyc_data : '0;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign rsp_data  = rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_READ;
      step_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rsp_q   <= '0;
      prev6_q <= 1'b0;
      first_q <= 1'b0;
      rec_q   <= 1'b0;
      susp_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: if (head_valid) begin
          if (legal) begin
            op_q   <= h_op;
            addr_q <= h_addr;
            data_q <= h_data;
            step_q <= start_step;
            rec_q  <= 1'b0;
            if (h_op == OP_RESUME) susp_q <= 1'b0;
            st_q   <= (h_op == OP_READ) ? ST_READ_REQ : ST_WRITE;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_WRITE: if (bus_ready) begin
          if (!last) begin
            step_q <= step_q + 1'b1;
          end else if (rec_q) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            case (op_q)
              OP_RESET: begin susp_q <= 1'b0; done_q <= 1'b1; st_q <= ST_IDLE; end
              OP_SUSP:  begin susp_q <= 1'b1; done_q <= 1'b1; st_q <= ST_IDLE; end
              default:  begin first_q <= 1'b1; st_q <= ST_POLL_CHK; end
            endcase
          end
        end
        ST_POLL_CHK: begin
          if (pop && legal) begin
            op_q   <= OP_SUSP;
            step_q <= 3'd2;
            st_q   <= ST_WRITE;
          end else begin
            st_q <= ST_POLL_REQ;
          end
        end
        ST_POLL_REQ: if (bus_ready) st_q <= ST_POLL_WAIT;
        ST_POLL_WAIT: if (bus_rvalid) begin
          if (first_q) begin
            prev6_q <= bus_rdata[6];
            first_q <= 1'b0;
            st_q    <= ST_POLL_CHK;
          end else if (bus_rdata[6] == prev6_q) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (bus_rdata[5]) begin
            rec_q  <= 1'b1;
            op_q   <= OP_RESET;
            step_q <= 3'd2;
            st_q   <= ST_WRITE;
          end else begin
            prev6_q <= bus_rdata[6];
            st_q    <= ST_POLL_CHK;
          end
        end
        ST_READ_REQ: if (bus_ready) st_q <= ST_READ_WAIT;
        ST_READ_WAIT: if (bus_rvalid) begin
          rsp_q  <= bus_rdata;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R12: a stalled bus request keeps its contents
  assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_we) &&
                                   $stable(bus_addr) && $stable(bus_wdata)));
  // R12: bus requests only come from an operation in progress
  assert_bus_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> busy);
  // R13: the two response pulses never coincide
  assert_resp_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R13: leaving the busy state is always reported
  assert_busy_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || error));
  // R11: while busy only suspend entries leave the queue
  assert_busy_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && busy) |-> (h_op == OP_SUSP));
  // R7: a recovery write follows only a failing poll read
  assert_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_q) |-> ($past(bus_rvalid) && $past(bus_rdata[5])));
endmodule

// File: tb/test_nor_op_sequencer.sv
module test_nor_op_sequencer;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic          bus_valid, bus_we;
  logic          bus_ready = 1'b1;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_rvalid = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          busy, done, error;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int failures = 0;

  // flash model controls
  bit stall = 1'b0;
  bit stat_mode = 1'b0;
  bit dq5_flag = 1'b0;
  bit tbit = 1'b0;
  int tog_left = 0;

  // bus cycle log
  int n_log = 0;
  bit lg_we [256];
  int lg_a  [256];
  int lg_d  [256];

  nor_op_sequencer #(.AW(AW), .DW(DW), .DEPTH(4)) i_nor_op_sequencer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .in_data(in_data),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .error(error),
    .rsp_data(rsp_data)
  );

  always #5 clk = ~clk;

  always @(negedge clk) bus_ready <= stall ? ~bus_ready : 1'b1;

  always @(posedge clk) begin
    bus_rvalid <= 1'b0;
    if (rst_n && bus_valid && bus_ready) begin
      if (n_log < 256) begin
        lg_we[n_log] = bus_we;
        lg_a[n_log]  = int'(bus_addr);
        lg_d[n_log]  = int'(bus_wdata);
        n_log++;
      end
      if (!bus_we) begin
        bus_rvalid <= 1'b1;
        if (stat_mode) begin
          if (tog_left > 0) begin
            tbit = ~tbit;
            tog_left--;
          end
          bus_rdata <= {9'b0, tbit, dq5_flag, 5'b0};
        end else begin
          bus_rdata <= bus_addr[15:0] ^ 16'h5A5A;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_writes();
    int n = 0;
    for (int i = 0; i < n_log; i++) if (lg_we[i]) n++;
    return n;
  endfunction

  function automatic int n_reads();
    int n = 0;
    for (int i = 0; i < n_log; i++) if (!lg_we[i]) n++;
    return n;
  endfunction

  task automatic chk_w(input int k, input int a, input int d, input string req);
    int seen = 0;
    int fa = -1;
    int fd = -1;
    for (int i = 0; i < n_log; i++) begin
      if (lg_we[i]) begin
        if (seen == k) begin fa = lg_a[i]; fd = lg_d[i]; end
        seen++;
      end
    end
    chk(fa == a && fd == d, req, (fa << 16) | (fd & 16'hFFFF), (a << 16) | d);
  endtask

  task automatic chk_reads_at(input int a, input string req);
    bit ok = 1'b1;
    int bad = a;
    for (int i = 0; i < n_log; i++)
      if (!lg_we[i] && lg_a[i] != a) begin ok = 1'b0; bad = lg_a[i]; end
    chk(ok, req, bad, a);
  endtask

  task automatic clear_log();
    @(negedge clk);
    n_log = 0;
  endtask

  task automatic push(input logic [2:0] op, input int a, input int d);
    @(negedge clk);
    in_op    = op;
    in_addr  = AW'(a);
    in_data  = DW'(d);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_resp(output bit got_done, output bit got_err);
    got_done = 1'b0;
    got_err  = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || error) begin
        got_done = done;
        got_err  = error;
        break;
      end
    end
  endtask

  task automatic wait_reads(input int n);
    for (int i = 0; i < 3000 && n_reads() < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(!busy, "R13 busy after reset", busy, 0);
    chk(!done && !error, "R13 pulses after reset", {done, error}, 0);
    chk(!bus_valid, "R13 bus_valid after reset", bus_valid, 0);
    chk(in_ready, "R13 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_program();
    bit d, e;
    stall = 1'b1; stat_mode = 1'b1; tog_left = 5; dq5_flag = 1'b0;
    clear_log();
    push(3'd1, 20'h12345, 16'hBEEF);
    wait_resp(d, e);
    chk(d && !e, "R6 program done", {d, e}, 2);
    chk(!busy, "R13 busy low at done", busy, 0);
    chk(n_writes() == 4, "R2 program write count", n_writes(), 4);
    chk_w(0, 'h555, 'hAA, "R2 unlock 1");
    chk_w(1, 'h2AA, 'h55, "R2 unlock 2");
    chk_w(2, 'h555, 'hA0, "R2 command");
    chk_w(3, 'h12345, 'hBEEF, "R2 target word");
    chk(n_reads() >= 2, "R6 poll reads", n_reads(), 2);
    chk_reads_at('h12345, "R6 poll address");
    @(negedge clk);
    chk(!done && !error, "R13 single pulse", {done, error}, 0);
    stall = 1'b0;
  endtask

  task automatic t_erase();
    bit d, e;
    stat_mode = 1'b1; tog_left = 3;
    clear_log();
    push(3'd2, 0, 0);
    wait_resp(d, e);
    chk(d && !e, "R3 erase done", {d, e}, 2);
    chk(n_writes() == 6, "R3 erase write count", n_writes(), 6);
    chk_w(0, 'h555, 'hAA, "R3 step 0");
    chk_w(1, 'h2AA, 'h55, "R3 step 1");
    chk_w(2, 'h555, 'h80, "R3 step 2");
    chk_w(3, 'h555, 'hAA, "R3 step 3");
    chk_w(4, 'h2AA, 'h55, "R3 step 4");
    chk_w(5, 'h555, 'h10, "R3 step 5");
  endtask

  task automatic t_reset_forms();
    bit d, e;
    clear_log();
    push(3'd3, 0, 0);
    wait_resp(d, e);
    chk(d && !e, "R4 short reset done", {d, e}, 2);
    chk(n_log == 1, "R4 short reset cycles", n_log, 1);
    chk_w(0, 'h555, 'hF0, "R4 short reset word");
    clear_log();
    push(3'd3, 0, 1);
    wait_resp(d, e);
    chk(d && !e, "R4 long reset done", {d, e}, 2);
    chk(n_log == 3, "R4 long reset cycles", n_log, 3);
    chk_w(0, 'h555, 'hAA, "R4 long unlock 1");
    chk_w(1, 'h2AA, 'h55, "R4 long unlock 2");
    chk_w(2, 'h555, 'hF0, "R4 long command");
  endtask

  task automatic t_read();
    bit d, e;
    stat_mode = 1'b0;
    clear_log();
    push(3'd0, 'h00ABC, 0);
    wait_resp(d, e);
    chk(d && !e, "R5 read done", {d, e}, 2);
    chk(rsp_data == (16'h0ABC ^ 16'h5A5A), "R5 read data", rsp_data, 16'h0ABC ^ 16'h5A5A);
    chk(n_log == 1 && n_reads() == 1, "R5 single read cycle", n_log, 1);
    chk_reads_at('h00ABC, "R5 read address");
  endtask

  task automatic t_reject(input logic [2:0] op, input string req);
    bit d, e;
    clear_log();
    push(op, 'h777, 0);
    wait_resp(d, e);
    chk(e && !d, req, {d, e}, 1);
    repeat (3) @(negedge clk);
    chk(n_log == 0, {req, " no bus cycle"}, n_log, 0);
  endtask

  task automatic t_dq5();
    bit d, e;
    stat_mode = 1'b1; tog_left = 100000; dq5_flag = 1'b1;
    clear_log();
    push(3'd1, 'h00040, 'h1234);
    wait_resp(d, e);
    chk(e && !d, "R7 failure reported", {d, e}, 1);
    chk(n_writes() == 5, "R7 write count", n_writes(), 5);
    chk_w(4, 'h555, 'hF0, "R7 recovery reset");
    dq5_flag = 1'b0;
  endtask

  task automatic t_suspend();
    bit d, e;
    stat_mode = 1'b1; tog_left = 100000;
    clear_log();
    push(3'd1, 'h00100, 'h4321);
    wait_reads(2);
    push(3'd4, 0, 0);
    wait_resp(d, e);
    chk(d && !e, "R9 suspend done", {d, e}, 2);
    chk(n_writes() == 5, "R9 suspend write count", n_writes(), 5);
    chk_w(4, 'h555, 'hB0, "R9 suspend word");
    t_reject(3'd1, "R8 program while suspended");
    stat_mode = 1'b0;
    clear_log();
    push(3'd0, 'h00200, 0);
    wait_resp(d, e);
    chk(d && rsp_data == (16'h0200 ^ 16'h5A5A), "R9 read while suspended",
        rsp_data, 16'h0200 ^ 16'h5A5A);
    stat_mode = 1'b1; tog_left = 4;
    clear_log();
    push(3'd5, 'h00100, 0);
    wait_resp(d, e);
    chk(d && !e, "R9 resume done", {d, e}, 2);
    chk(n_writes() == 1, "R9 resume write count", n_writes(), 1);
    chk_w(0, 'h555, 'h30, "R9 resume word");
    chk_reads_at('h00100, "R9 resume poll address");
  endtask

  task automatic t_erase_suspend();
    bit d, e;
    stat_mode = 1'b1; tog_left = 30;
    clear_log();
    push(3'd2, 0, 0);
    wait_reads(2);
    push(3'd4, 0, 0);
    wait_resp(d, e);
    chk(d && !e, "R10 erase completes", {d, e}, 2);
    chk(n_writes() == 6, "R10 no suspend write", n_writes(), 6);
    wait_resp(d, e);
    chk(!d && !e, "R10 no extra response", {d, e}, 0);
    chk(in_ready && !busy, "R10 queue drained", {in_ready, busy}, 2);
  endtask

  task automatic t_queue();
    bit d, e;
    int got;
    stall = 1'b1; stat_mode = 1'b1; tog_left = 100000;
    clear_log();
    push(3'd1, 'h00300, 'h0F0F);
    wait_reads(2);
    for (int k = 1; k <= 4; k++) push(3'd0, k, 0);
    @(negedge clk);
    chk(!in_ready, "R1 queue full", in_ready, 0);
    repeat (20) @(negedge clk);
    chk_reads_at('h00300, "R11 queued reads wait");
    chk(busy, "R11 still busy", busy, 1);
    tog_left = 0;
    wait_resp(d, e);
    chk(d && !e, "R6 program done after queue", {d, e}, 2);
    stat_mode = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      wait_resp(d, e);
      got = int'(rsp_data);
      chk(d && got == (k ^ 'h5A5A), "R1 in-order read", got, k ^ 'h5A5A);
    end
    stall = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_state();
    t_program();
    t_erase();
    t_reset_forms();
    t_read();
    t_reject(3'd6, "R8 op code 6");
    t_reject(3'd7, "R8 op code 7");
    t_reject(3'd4, "R8 suspend while idle");
    t_reject(3'd5, "R8 resume not suspended");
    t_dq5();
    t_suspend();
    t_erase_suspend();
    t_queue();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule